// File: doc/BRIEF.md
# Reset and Interrupt Supervisor

This block is the system-management controller of a power-management device. It drives an active-low system reset and an active-low interrupt towards the host processor, and it reports whether the system is enabled. The reset is held low from power-on until a timeout set by parameter has run out. A direct drive of the hard-reset pushbutton pulls the reset low again for as long as the button is pressed. A full timeout then runs again after the release.

The interrupt has two sources. A pushbutton press, either the hard or the soft button, pulls the interrupt low only while the button is held. A fault flag that the host has not masked is latched and keeps the interrupt low until the host reads the status register. A small register port stands in for the host serial bus. Through it the host writes a per-fault mask and reads the latched fault status, and that status read clears the latched bits. All external inputs pass through two-flop synchronisers before any logic uses them.

Top module: `sysmgr_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes this state: `sys_rst_n` = 0, `irq_n` = 1, `sys_enabled` = 0, fault mask all ones, fault status all zeros.
- R2: Every external input reaches the logic two clock edges after it is sampled. With the hard button idle, `sys_rst_n` rises after the LIMIT-th rising edge following reset release. LIMIT = `CLK_KHZ` * `TIMEOUT_MS` clock cycles, which by default is 13,000,000 cycles (260 ms at 50 MHz).
- R3: A low level on `hard_rst_n` pulls `sys_rst_n` low no later than the third rising edge after it is applied. No debounce delay is added.
- R4: `sys_rst_n` stays low while `hard_rst_n` is low. After release it stays low for a further full LIMIT cycles. A new press during that wait restarts the count from zero at the next release.
- R5: `irq_n` is low while either `hard_rst_n` or `soft_req_n` is held low, and it returns high once both are released, provided no fault status bit is set.
- R6: A fault flag whose mask bit is 0 sets its status bit. A set status bit keeps `irq_n` low until a status read clears it, even after the flag goes away.
- R7: A fault flag whose mask bit is 1 never sets its status bit and never pulls `irq_n` low.
- R8: A status read (`reg_rd` = 1, `reg_addr` = 1) clears the status bits that were set at that edge. A fault that is still unmasked and present at that edge keeps its bit set.
- R9: `sys_enabled` is 1 while any of the four `reg_en` inputs is 1, and it drops to 0 only when all four are 0.
- R10: A write with `reg_addr` = 0 loads the mask from `reg_wdata`. `reg_rdata` shows the mask when `reg_addr` = 0 and the status when `reg_addr` = 1. A write with `reg_addr` = 1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hard_rst_n | input | 1 | Hard-reset pushbutton, active low |
| soft_req_n | input | 1 | Soft pushbutton request, active low |
| reg_en | input | 4 | Regulator enable inputs, active high |
| fault_in | input | NF | Fault flags, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = fault mask, 1 = fault status |
| reg_wdata | input | NF | Write data for the mask |
| reg_rdata | output | NF | Read data selected by `reg_addr` |
| sys_rst_n | output | 1 | System reset, active low |
| irq_n | output | 1 | Interrupt, active low |
| sys_enabled | output | 1 | System enabled indication |

## Verification
A wrong count in the reset timer shows as `sys_rst_n` rising one or more cycles off the model's edge, either after power-on or after each hard-button release. A press in the middle of the countdown reveals a timer that fails to restart. A status bit that is set or cleared wrongly appears on `reg_rdata` at once when the status is selected, and it shows on `irq_n` one edge later. The mask state appears on `reg_rdata` in the same cycle it changes. The bench compares every output against its model on every cycle, so any such fault is reported in the cycle where it first reaches a port.

// File: rtl/sysmgr_pkg.sv
// Shared definitions for the reset and interrupt supervisor.
package sysmgr_pkg;

    // Register port addresses (one address bit).
    typedef enum logic {
        ADDR_MASK   = 1'b0,
        ADDR_STATUS = 1'b1
    } sysmgr_addr_e;

    // Timeout length in clock cycles from clock rate (kHz) and time (ms).
    function automatic int unsigned timeout_cycles(input int unsigned khz,
                                                   input int unsigned ms);
        return khz * ms;
    endfunction

endpackage

// File: rtl/sysmgr_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; a reset value per bit keeps idle
// levels (inactive pushbuttons) from reading as events after reset.
module sysmgr_sync #(
    parameter int unsigned W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage capture into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= INIT;
            q      <= INIT;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/sysmgr_rst_timer.sv
// Reset timeout counter. The reset output stays asserted while hold is
// high and then for LIMIT more cycles; each new hold restarts the count.
// Assumes LIMIT >= 2 and that hold is already synchronous.
module sysmgr_rst_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic rst_out_n
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Counts cycles since release; clears on every hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered release flag so the output never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            done_q <= 1'b0;
        end else if (cnt_q == CW'(LIMIT - 1)) begin
            done_q <= 1'b1;
        end
    end

    assign rst_out_n = done_q;
endmodule

// File: rtl/sysmgr_fault_regs.sv
// Fault mask and latched fault status with a host register port.
// A status read clears the bits latched at that edge; a fault still
// present and unmasked at that edge keeps its bit. Assumes faults are
// already synchronous.
module sysmgr_fault_regs
    import sysmgr_pkg::*;
#(
    parameter int unsigned NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] fault_s,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic          reg_addr,
    input  logic [NF-1:0] reg_wdata,
    output logic [NF-1:0] reg_rdata,
    output logic [NF-1:0] mask_q,
    output logic [NF-1:0] status_q
);
    logic          rd_status;
    logic [NF-1:0] clr_bits;
    logic [NF-1:0] set_bits;

    // Decode which bits a status read removes and which faults latch.
    always_comb begin
        rd_status = reg_rd && (reg_addr == ADDR_STATUS);
        clr_bits  = rd_status ? status_q : '0;
        set_bits  = fault_s & ~mask_q;
    end

    // Mask register, written by the host, all masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (reg_wr && (reg_addr == ADDR_MASK)) begin
            mask_q <= reg_wdata;
        end
    end

    // Sticky status: setting wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | set_bits;
        end
    end

    // Read data multiplexer.
    assign reg_rdata = (reg_addr == ADDR_STATUS) ? status_q : mask_q;
endmodule

// File: rtl/sysmgr_supervisor.sv
// Reset and interrupt supervisor top. Synchronises all inputs, holds
// the system reset through a parameterised timeout, drives a
// registered interrupt from pushbutton levels and latched faults, and
// tracks the enabled state from four enable inputs.
// Assumes a free-running clk and a synchronous active-low rst_n.
module sysmgr_supervisor
    import sysmgr_pkg::*;
#(
    parameter int unsigned NF         = 4,
    parameter int unsigned CLK_KHZ    = 50000,
    parameter int unsigned TIMEOUT_MS = 260
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hard_rst_n,
    input  logic          soft_req_n,
    input  logic [3:0]    reg_en,
    input  logic [NF-1:0] fault_in,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic          reg_addr,
    input  logic [NF-1:0] reg_wdata,
    output logic [NF-1:0] reg_rdata,
    output logic          sys_rst_n,
    output logic          irq_n,
    output logic          sys_enabled
);
    localparam int unsigned LIMIT = timeout_cycles(CLK_KHZ, TIMEOUT_MS);
    localparam int unsigned SW    = 2 + 4 + NF;
    localparam logic [SW-1:0] SYNC_INIT = {2'b11, {(4 + NF){1'b0}}};

    logic [SW-1:0] sync_q;
    logic          hard_s_n;
    logic          soft_s_n;
    logic [3:0]    en_s;
    logic [NF-1:0] fault_s;
    logic [NF-1:0] mask_q;
    logic [NF-1:0] status_q;
    logic          hold_s;
    logic          pb_any_s;
    logic          irq_q;
    logic          en_q;

    sysmgr_sync #(.W(SW), .INIT(SYNC_INIT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hard_rst_n, soft_req_n, reg_en, fault_in}),
        .q     (sync_q)
    );

    assign {hard_s_n, soft_s_n, en_s, fault_s} = sync_q;
    assign hold_s   = !hard_s_n;
    assign pb_any_s = !hard_s_n || !soft_s_n;

    sysmgr_rst_timer #(.LIMIT(LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold_s),
        .rst_out_n (sys_rst_n)
    );

    sysmgr_fault_regs #(.NF(NF)) u_faults (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_s   (fault_s),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mask_q    (mask_q),
        .status_q  (status_q)
    );

    // Registered interrupt request: button level or any latched fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pb_any_s || (|status_q);
        end
    end

    // Enabled while any enable input is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= |en_s;
        end
    end

    assign irq_n       = !irq_q;
    assign sys_enabled = en_q;
endmodule

// File: rtl/sysmgr_checker.sv
// Property checker for the supervisor, attached by bind below.
module sysmgr_checker #(
    parameter int unsigned NF = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_rst_n,
    input logic          irq_n,
    input logic          hold_s,
    input logic          pb_any_s,
    input logic          reg_rd,
    input logic          reg_addr,
    input logic [NF-1:0] mask_q,
    input logic [NF-1:0] status_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !sys_rst_n);

    // R3
    hard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> !sys_rst_n);

    // R4
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(!hold_s));

    // R5
    button_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_any_s |=> !irq_n);

    // R6
    sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q != '0) && !(reg_rd && reg_addr)) |=> !irq_n);

    // R7
    masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & $past(mask_q)) == '0));
endmodule

bind sysmgr_supervisor sysmgr_checker #(.NF(NF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_n (sys_rst_n),
    .irq_n     (irq_n),
    .hold_s    (hold_s),
    .pb_any_s  (pb_any_s),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .mask_q    (mask_q),
    .status_q  (status_q)
);

// File: tb/sysmgr_supervisor_tb.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module sysmgr_supervisor_tb;
    localparam int NF = 4;
    localparam int KHZ = 24;
    localparam int MS = 1;
    localparam int LIMIT = KHZ * MS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hard_rst_n = 1'b1;
    logic          soft_req_n = 1'b1;
    logic [3:0]    reg_en = '0;
    logic [NF-1:0] fault_in = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic          reg_addr = 1'b0;
    logic [NF-1:0] reg_wdata = '0;
    logic [NF-1:0] reg_rdata;
    logic          sys_rst_n;
    logic          irq_n;
    logic          sys_enabled;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    sysmgr_supervisor #(.NF(NF), .CLK_KHZ(KHZ), .TIMEOUT_MS(MS)) u_dut (
        .clk, .rst_n, .hard_rst_n, .soft_req_n, .reg_en, .fault_in,
        .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .sys_rst_n, .irq_n, .sys_enabled
    );

    // Reference model state: input history and behavioural registers.
    logic [1:0]    hard_hist = 2'b11, soft_hist = 2'b11;
    logic [3:0]    en_hist [2];
    logic [NF-1:0] flt_hist [2];
    int            since_rel = 0;
    logic [NF-1:0] m_mask = '1, m_stat = '0;
    logic          e_irq_n = 1'b1, e_en = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hard_hist = 2'b11; soft_hist = 2'b11;
            en_hist[0] = '0; en_hist[1] = '0;
            flt_hist[0] = '0; flt_hist[1] = '0;
            since_rel = 0; m_mask = '1; m_stat = '0;
            e_irq_n = 1'b1; e_en = 1'b0;
        end else begin
            logic          hard_seen, soft_seen;
            logic [NF-1:0] flt_seen, cleared;
            hard_seen = hard_hist[1];
            soft_seen = soft_hist[1];
            flt_seen  = flt_hist[1];
            if (!hard_seen) since_rel = 0;
            else if (since_rel < LIMIT) since_rel++;
            e_irq_n = !(!hard_seen || !soft_seen || (m_stat != 0));
            e_en    = (en_hist[1] != 0);
            cleared = (reg_rd && reg_addr) ? m_stat : '0;
            m_stat  = (m_stat & ~cleared) | (flt_seen & ~m_mask);
            if (reg_wr && !reg_addr) m_mask = reg_wdata;
            hard_hist = {hard_hist[0], hard_rst_n};
            soft_hist = {soft_hist[0], soft_req_n};
            en_hist[1] = en_hist[0]; en_hist[0] = reg_en;
            flt_hist[1] = flt_hist[0]; flt_hist[0] = fault_in;
        end
    end

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            check("sys_rst_n", 32'(sys_rst_n), 32'(since_rel >= LIMIT));
            check("irq_n", 32'(irq_n), 32'(e_irq_n));
            check("sys_enabled", 32'(sys_enabled), 32'(e_en));
            check("reg_rdata", 32'(reg_rdata), 32'(reg_addr ? m_stat : m_mask));
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic status_read();
        reg_addr = 1'b1; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        tick(3);
        check("R1 reset sys_rst_n", 32'(sys_rst_n), 32'd0);
        check("R1 reset irq_n", 32'(irq_n), 32'd1);
        check("R1 reset mask", 32'(reg_rdata), 32'hF);
        rst_n = 1'b1;
        // R2: power-on timeout, rises after the LIMIT-th edge
        tag = "R2";
        tick(LIMIT - 1);
        check("R2 still low", 32'(sys_rst_n), 32'd0);
        tick();
        check("R2 released", 32'(sys_rst_n), 32'd1);
        tick(4);
        // R9: enabled while any enable is set
        tag = "R9";
        reg_en = 4'b0001; tick(4);
        reg_en = 4'b0101; tick(2);
        reg_en = 4'b0100; tick(4);
        reg_en = 4'b0000; tick(4);
        // R10: mask write and read back; status writes ignored
        tag = "R10";
        reg_addr = 1'b0; reg_wdata = 4'b0011; reg_wr = 1'b1; tick();
        reg_wr = 1'b0; tick(2);
        check("R10 mask readback", 32'(reg_rdata), 32'h3);
        reg_addr = 1'b1; reg_wdata = 4'b1111; reg_wr = 1'b1; tick();
        reg_wr = 1'b0; tick();
        check("R10 status unchanged", 32'(reg_rdata), 32'h0);
        reg_addr = 1'b0; tick();
        check("R10 mask unchanged", 32'(reg_rdata), 32'h3);
        // R7: masked fault never latches
        tag = "R7";
        fault_in = 4'b0001; tick(5);
        fault_in = 4'b0000; tick(4);
        check("R7 irq idle", 32'(irq_n), 32'd1);
        // R6: one-cycle unmasked fault latches and stays
        tag = "R6";
        reg_addr = 1'b1;
        fault_in = 4'b0100; tick();
        fault_in = 4'b0000; tick(10);
        check("R6 sticky irq", 32'(irq_n), 32'd0);
        // R8: read clears, irq returns
        tag = "R8";
        status_read(); tick(3);
        check("R8 cleared", 32'(reg_rdata), 32'h0);
        check("R8 irq released", 32'(irq_n), 32'd1);
        fault_in = 4'b1000; tick(4);
        status_read(); tick(2);
        check("R8 persistent kept", 32'(reg_rdata), 32'h8);
        fault_in = 4'b0000; tick(3);
        status_read(); tick(3);
        check("R8 cleared later", 32'(reg_rdata), 32'h0);
        // R5: soft button gives transient irq
        tag = "R5";
        soft_req_n = 1'b0; tick(5);
        check("R5 irq low", 32'(irq_n), 32'd0);
        soft_req_n = 1'b1; tick(5);
        check("R5 irq back", 32'(irq_n), 32'd1);
        // R3: hard button pulls reset low within three edges
        tag = "R3";
        hard_rst_n = 1'b0; tick(3);
        check("R3 reset low", 32'(sys_rst_n), 32'd0);
        tick(3);
        // R4: full timeout after release, restarted by a new press
        tag = "R4";
        hard_rst_n = 1'b1; tick(10);
        hard_rst_n = 1'b0; tick(3);
        hard_rst_n = 1'b1; tick(LIMIT);
        check("R4 still low", 32'(sys_rst_n), 32'd0);
        tick(4);
        check("R4 released", 32'(sys_rst_n), 32'd1);
        tick(4);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule